// File: doc/BRIEF.md
# FIFO Threshold Offset Unit

This block holds the two threshold offsets of a dual-clock FIFO and turns the FIFO fill counts into two active-low warning flags: one that warns when the stored data is close to empty, and one that warns when the free space is close to full. The FIFO memory and its pointers are outside the block. The block only receives the fill count as seen from the read side and as seen from the write side.

While master reset is held, one of eight built-in default offsets is loaded into both registers. The default is chosen by two preset-select pins and the load pin. After reset, the offsets can be rewritten bit by bit through a slow serial clock and data pin, or a whole word at a time from the write data bus. They can be read back word by word over the read data bus. The load pin steers the write, read and serial strobes to these registers. Without it, all three strobes are ignored.

The readback output is a valid-only stream. `rd_valid` marks the single read-clock cycle in which `rd_data` holds a returned offset. There is no back-pressure: the consumer must take the word in that cycle. The write bus and the serial input always accept, so they have no ready signal either. Offsets are treated as static configuration and are read across clock domains without resynchronisation. They must not be reprogrammed while the flags are being relied on.

Top module: `fifo_thresh_unit`

## Requirements
- R1: While `mrst_n` is low, at each write-clock edge both offsets take the value 2^(k+3)-1, where k = {preset_sel[1], preset_sel[0], load} as a 3-bit number. This gives 7 for k=0, up to 1023 for k=7.
- R2: While `mrst_n` is low, the write toggle, read toggle and serial bit position return to their start values. `pae_n` is driven low, `paf_n` is driven high and `rd_valid` is low.
- R3: At a write-clock edge with `wen` and `load` both high, `wr_data` is stored into the register chosen by the write toggle, and the toggle flips. The empty-side offset is chosen first after reset.
- R4: A rising `sclk` edge with `sen` and `load` high shifts in one bit of `sdin`. The first 12 bits fill the empty-side offset from bit 0 upward. The next 12 bits fill the full-side offset the same way. The 25th bit starts again at the empty-side offset. Each `sclk` level must last at least three write-clock periods, and a bit is stored within four write-clock cycles of its edge.
- R5: At a read-clock edge with `ren` and `load` high, the register chosen by the read toggle (empty-side first) appears on `rd_data` after that edge, `rd_valid` is high for that one cycle, and the read toggle flips. The read toggle is independent of the write toggle and of the loading method.
- R6: With `load` low, `wen`, `ren` and serial strobes change neither offset nor either toggle, and `rd_valid` stays low.
- R7: `pae_n`, registered on `rclk`, is low exactly when the `rd_count` sampled at the previous read-clock edge is at or below the empty-side offset.
- R8: `paf_n`, registered on `wclk`, is low exactly when DEPTH minus the `wr_count` sampled at the previous write-clock edge is at or below the full-side offset.
- R9: Each offset can take any value from 0 to DEPTH-1, independently of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock; offset store and full-side flag |
| rclk | input | 1 | Read-side clock; readback and empty-side flag |
| sclk | input | 1 | Serial programming clock, oversampled in the write domain |
| mrst_n | input | 1 | Master reset, active low, synchronous in each domain |
| preset_sel | input | 2 | Default-offset select, sampled during reset |
| load | input | 1 | Steers strobes to the offset registers; also the low preset-select bit during reset |
| sen | input | 1 | Serial enable |
| sdin | input | 1 | Serial data bit |
| wen | input | 1 | Write strobe |
| wr_data | input | 12 | Offset word for parallel load |
| ren | input | 1 | Read strobe |
| rd_data | output | 12 | Returned offset word |
| rd_valid | output | 1 | Marks a returned word, one cycle, no back-pressure |
| rd_count | input | 13 | Words stored, as seen by the read side |
| wr_count | input | 13 | Words stored, as seen by the write side |
| pae_n | output | 1 | Almost-empty warning, active low |
| paf_n | output | 1 | Almost-full warning, active low |

## Verification
A wrong toggle shows up at once at the read port: the two offsets come back swapped on the next readback pair, or the next parallel pair lands in the wrong registers. A wrong serial bit position or bit order shows as shifted or mixed offset values after 24 serial bits. A wrong threshold compare shows on the flag one clock after the count crosses the offset. The bench therefore drives counts on both sides of each offset, including offsets 0 and DEPTH-1.

// File: rtl/fifo_thresh_pkg.sv
package fifo_thresh_pkg;
  // default offset for preset index k: 2^(k+3)-1
  function automatic int unsigned preset_level(input int unsigned k);
    return (32'd1 << (k + 3)) - 32'd1;
  endfunction
endpackage

// File: rtl/thresh_serial_rx.sv
module thresh_serial_rx #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic sen,
  input  logic sdin,
  output logic bit_stb,
  output logic bit_val
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sclk_s, sen_s, sdin_s;
  logic         sclk_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          sclk_s <= '0; sen_s <= '0; sdin_s <= '0;
        end else begin
          sclk_s <= sclk; sen_s <= sen; sdin_s <= sdin;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          sclk_s <= '0; sen_s <= '0; sdin_s <= '0;
        end else begin
          sclk_s <= {sclk_s[TOP-1:0], sclk};
          sen_s  <= {sen_s[TOP-1:0], sen};
          sdin_s <= {sdin_s[TOP-1:0], sdin};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s[TOP];
  end

  assign bit_stb = sclk_s[TOP] & ~sclk_d & sen_s[TOP];
  assign bit_val = sdin_s[TOP];

  // R4: one strobe per serial clock edge
  p_stb_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb);
endmodule

// File: rtl/thresh_store.sv
module thresh_store
  import fifo_thresh_pkg::*;
#(
  parameter int OFS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       preset_sel,
  input  logic             load,
  input  logic             wen,
  input  logic [OFS_W-1:0] wr_data,
  input  logic             bit_stb,
  input  logic             bit_val,
  output logic [OFS_W-1:0] ae_ofs,
  output logic [OFS_W-1:0] af_ofs
);
  localparam int BIT_W = $clog2(2 * OFS_W);
  localparam int IDX_W = (OFS_W > 1) ? $clog2(OFS_W) : 1;
  localparam logic [BIT_W-1:0] LAST_POS = BIT_W'(2 * OFS_W - 1);

  logic [BIT_W-1:0] bit_pos;
  logic             wtog;
  logic             lane_ae;
  logic [IDX_W-1:0] lane;
  logic [OFS_W-1:0] preset_v;

  always_comb begin
    preset_v = OFS_W'(preset_level({29'd0, preset_sel, load}));
    lane_ae  = (bit_pos < BIT_W'(OFS_W));
    lane     = lane_ae ? IDX_W'(bit_pos) : IDX_W'(bit_pos - BIT_W'(OFS_W));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ae_ofs  <= preset_v;
      af_ofs  <= preset_v;
      wtog    <= 1'b0;
      bit_pos <= '0;
    end else if (load && wen) begin
      if (!wtog) ae_ofs <= wr_data;
      else       af_ofs <= wr_data;
      wtog <= ~wtog;
    end else if (load && bit_stb) begin
      if (lane_ae) ae_ofs[lane] <= bit_val;
      else         af_ofs[lane] <= bit_val;
      bit_pos <= (bit_pos == LAST_POS) ? '0 : bit_pos + 1'b1;
    end
  end

  // R6: nothing moves without load
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(ae_ofs) && $stable(af_ofs) && $stable(wtog) && $stable(bit_pos)));
  // R3: every accepted parallel word flips the toggle
  p_wtog_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && wen) |=> (wtog != $past(wtog)));
  // R4: serial position wraps to the empty-side register
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !wen && bit_stb && bit_pos == LAST_POS) |=> (bit_pos == '0));
endmodule

// File: rtl/thresh_readback.sv
module thresh_readback #(
  parameter int OFS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             ren,
  input  logic [OFS_W-1:0] ae_ofs,
  input  logic [OFS_W-1:0] af_ofs,
  output logic [OFS_W-1:0] rd_data,
  output logic             rd_valid
);
  logic rtog;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rtog     <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (load && ren) begin
      rd_data  <= rtog ? af_ofs : ae_ofs;
      rd_valid <= 1'b1;
      rtog     <= ~rtog;
    end else begin
      rd_valid <= 1'b0;
    end
  end

  // R5: a qualified read returns a word on the next cycle
  p_rvalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && ren) |=> rd_valid);
  // R6: no word without load and read strobe
  p_rquiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && ren) |=> !rd_valid);
endmodule

// File: rtl/thresh_flag.sv
module thresh_flag #(
  parameter int W = 13,
  parameter bit RESET_ASSERTED = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] limit,
  output logic         flag_n
);
  always_ff @(posedge clk) begin
    if (!rst_n) flag_n <= ~RESET_ASSERTED;
    else        flag_n <= ~(level <= limit);
  end

  // R7 (and R8 for the full-side instance): flag follows the compare one edge later
  p_flag_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (level <= limit) |=> !flag_n);
  p_flag_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (level > limit) |=> flag_n);
endmodule

// File: rtl/fifo_thresh_unit.sv
module fifo_thresh_unit #(
  parameter int DEPTH       = 4096,
  parameter int SYNC_STAGES = 2,
  localparam int OFS_W      = $clog2(DEPTH),
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             sclk,
  input  logic             mrst_n,
  input  logic [1:0]       preset_sel,
  input  logic             load,
  input  logic             sen,
  input  logic             sdin,
  input  logic             wen,
  input  logic [OFS_W-1:0] wr_data,
  input  logic             ren,
  output logic [OFS_W-1:0] rd_data,
  output logic             rd_valid,
  input  logic [CNT_W-1:0] rd_count,
  input  logic [CNT_W-1:0] wr_count,
  output logic             pae_n,
  output logic             paf_n
);
  logic             bit_stb, bit_val;
  logic [OFS_W-1:0] ae_ofs, af_ofs;
  logic [CNT_W-1:0] free_cnt;

  assign free_cnt = CNT_W'(DEPTH) - wr_count;

  thresh_serial_rx #(.SYNC_STAGES(SYNC_STAGES)) u_srx (
    .clk(wclk), .rst_n(mrst_n), .sclk(sclk), .sen(sen), .sdin(sdin),
    .bit_stb(bit_stb), .bit_val(bit_val));

  thresh_store #(.OFS_W(OFS_W)) u_store (
    .clk(wclk), .rst_n(mrst_n), .preset_sel(preset_sel), .load(load),
    .wen(wen), .wr_data(wr_data), .bit_stb(bit_stb), .bit_val(bit_val),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs));

  thresh_readback #(.OFS_W(OFS_W)) u_rb (
    .clk(rclk), .rst_n(mrst_n), .load(load), .ren(ren),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs), .rd_data(rd_data), .rd_valid(rd_valid));

  thresh_flag #(.W(CNT_W), .RESET_ASSERTED(1'b1)) u_ae_flag (
    .clk(rclk), .rst_n(mrst_n), .level(rd_count),
    .limit(CNT_W'(ae_ofs)), .flag_n(pae_n));

  thresh_flag #(.W(CNT_W), .RESET_ASSERTED(1'b0)) u_af_flag (
    .clk(wclk), .rst_n(mrst_n), .level(free_cnt),
    .limit(CNT_W'(af_ofs)), .flag_n(paf_n));
endmodule

// File: tb/tb_fifo_thresh_unit.sv
module tb_fifo_thresh_unit;
  localparam int WCLK_P = 10;
  localparam int RCLK_P = 14;
  localparam int DEPTH  = 4096;
  localparam int OFS_W  = 12;
  localparam int CNT_W  = 13;

  logic wclk = 0, rclk = 0, sclk = 0, mrst_n = 0;
  logic [1:0] preset_sel = 0;
  logic load = 0, sen = 0, sdin = 0, wen = 0, ren = 0;
  logic [OFS_W-1:0] wr_data = 0;
  logic [OFS_W-1:0] rd_data;
  logic rd_valid, pae_n, paf_n;
  logic [CNT_W-1:0] rd_count = 0, wr_count = 0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(WCLK_P/2) wclk = ~wclk;
  always #(RCLK_P/2) rclk = ~rclk;

  fifo_thresh_unit dut (
    .wclk(wclk), .rclk(rclk), .sclk(sclk), .mrst_n(mrst_n),
    .preset_sel(preset_sel), .load(load), .sen(sen), .sdin(sdin),
    .wen(wen), .wr_data(wr_data), .ren(ren), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_count(rd_count), .wr_count(wr_count),
    .pae_n(pae_n), .paf_n(paf_n));

  function automatic int preset_of(int k);
    return (1 << (k + 3)) - 1;
  endfunction

  function automatic bit ae_low(int cnt, int ofs);
    return cnt <= ofs;
  endfunction

  function automatic bit af_low(int wc, int ofs);
    return (DEPTH - wc) <= ofs;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(int k);
    mrst_n = 0; preset_sel = k[2:1]; load = k[0];
    wen = 0; ren = 0; sen = 0; sclk = 0;
    repeat (5) @(negedge rclk);
    @(negedge wclk);
    mrst_n = 1; load = 0;
    repeat (3) @(negedge wclk);
  endtask

  task automatic write_pair(int a, int b);
    @(negedge wclk); load = 1; wen = 1; wr_data = a[OFS_W-1:0];
    @(negedge wclk); wr_data = b[OFS_W-1:0];
    @(negedge wclk); wen = 0; load = 0;
  endtask

  task automatic read_pair(output int a, output int b, input string req);
    @(negedge rclk); load = 1; ren = 1;
    @(negedge rclk); check({req, " valid1"}, rd_valid, 1); a = rd_data;
    @(negedge rclk); check({req, " valid2"}, rd_valid, 1); b = rd_data; ren = 0;
    @(negedge rclk); check({req, " valid end"}, rd_valid, 0); load = 0;
  endtask

  task automatic ser_bit(bit v, bit with_load);
    @(negedge wclk); load = with_load; sen = 1; sdin = v; sclk = 0;
    repeat (3) @(negedge wclk); sclk = 1;
    repeat (3) @(negedge wclk); sclk = 0;
  endtask

  task automatic ser_pair(int a, int b);
    for (int i = 0; i < 2 * OFS_W; i++)
      ser_bit(i < OFS_W ? a[i] : b[i - OFS_W], 1'b1);
    repeat (6) @(negedge wclk);
    sen = 0; load = 0;
  endtask

  task automatic flag_ae(int cnt, int ofs, string req);
    @(negedge rclk); rd_count = CNT_W'(cnt);
    @(negedge rclk); check(req, pae_n, !ae_low(cnt, ofs));
  endtask

  task automatic flag_af(int wc, int ofs, string req);
    @(negedge wclk); wr_count = CNT_W'(wc);
    @(negedge wclk); check(req, paf_n, !af_low(wc, ofs));
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int a, b, x, y, seed;
    seed = $urandom(32'd7741);

    // R2: reset state of the outputs
    mrst_n = 0; rd_count = 13'd100; wr_count = 13'd0;
    repeat (4) @(negedge rclk);
    check("R2 pae_n in reset", pae_n, 0);
    check("R2 paf_n in reset", paf_n, 1);
    check("R2 rd_valid in reset", rd_valid, 0);

    // R1: all eight presets
    for (int k = 0; k < 8; k++) begin
      do_reset(k);
      read_pair(a, b, "R1 read");
      check("R1 empty-side preset", a, preset_of(k));
      check("R1 full-side preset", b, preset_of(k));
    end

    // R3 / R5: random parallel pairs read back in order
    for (int i = 0; i < 6; i++) begin
      x = $urandom % DEPTH; y = $urandom % DEPTH;
      write_pair(x, y);
      read_pair(a, b, "R5 read");
      check("R3 empty-side word", a, x);
      check("R3 full-side word", b, y);
    end

    // R2: reset returns toggles to the empty side after an odd access
    @(negedge wclk); load = 1; wen = 1; wr_data = 12'd55;
    @(negedge wclk); wen = 0; load = 0;
    @(negedge rclk); load = 1; ren = 1;
    @(negedge rclk); ren = 0; load = 0;
    do_reset(2);
    write_pair(321, 654);
    read_pair(a, b, "R2 toggles");
    check("R2 write toggle restart", a, 321);
    check("R2 read toggle restart", b, 654);

    // R4: serial load, LSB first, empty side first, then wrap
    do_reset(0);
    x = $urandom % DEPTH; y = $urandom % DEPTH;
    ser_pair(x, y);
    read_pair(a, b, "R4 read");
    check("R4 serial empty side", a, x);
    check("R4 serial full side", b, y);
    ser_pair(12'h0A5, 12'hF3C);
    read_pair(a, b, "R4 read wrap");
    check("R4 wrap empty side", a, 12'h0A5);
    check("R4 wrap full side", b, 12'hF3C);

    // R6: strobes without load are ignored
    write_pair(1111, 2222);
    @(negedge wclk); load = 0; wen = 1;
    for (int i = 0; i < 5; i++) begin
      wr_data = OFS_W'($urandom); @(negedge wclk);
    end
    wen = 0;
    for (int i = 0; i < 3; i++) ser_bit(1'b1, 1'b0);
    repeat (6) @(negedge wclk); sen = 0;
    @(negedge rclk); ren = 1; load = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge rclk); check("R6 rd_valid without load", rd_valid, 0);
    end
    ren = 0;
    read_pair(a, b, "R6 read");
    check("R6 empty side kept", a, 1111);
    check("R6 full side kept", b, 2222);
    write_pair(77, 88);
    read_pair(a, b, "R6 toggle kept");
    check("R6 write toggle kept", a, 77);
    check("R6 read toggle kept", b, 88);

    // R7 / R8: random counts around random offsets
    for (int r = 0; r < 4; r++) begin
      x = $urandom % DEPTH; y = $urandom % DEPTH;
      write_pair(x, y);
      for (int i = 0; i < 10; i++) begin
        a = x + int'($urandom % 5) - 2; if (a < 0) a = 0;
        flag_ae(a, x, "R7 pae_n random");
        b = (DEPTH - y) + int'($urandom % 5) - 2;
        if (b < 0) b = 0; if (b > DEPTH) b = DEPTH;
        flag_af(b, y, "R8 paf_n random");
      end
    end

    // R9: offset extremes
    write_pair(0, DEPTH - 1);
    flag_ae(0, 0, "R9 empty offset 0 at count 0");
    flag_ae(1, 0, "R9 empty offset 0 at count 1");
    flag_af(1, DEPTH - 1, "R9 full offset max at one word");
    flag_af(0, DEPTH - 1, "R9 full offset max when empty");
    write_pair(DEPTH - 1, 0);
    flag_ae(DEPTH - 1, DEPTH - 1, "R9 empty offset max");
    flag_ae(DEPTH, DEPTH - 1, "R9 empty offset max at full");
    flag_af(DEPTH, 0, "R9 full offset 0 at full");
    flag_af(DEPTH - 1, 0, "R9 full offset 0 one free");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule